// File: doc/BRIEF.md
# Clock Loss Detector and Reset Combiner

This block watches a processor clock output using a free-running 16 MHz reference clock, which is itself divided down from a 32 MHz oscillator. The monitored clock is brought into the reference domain through a flop synchronizer, and its rising edges are detected there. Every detected edge restarts a timeout counter. If the counter reaches its limit, the monitored clock has gone quiet for too long. The default limit is 158,400 reference cycles, which is 9.9 ms at 16 MHz. The block then flags a clock loss.

A clock loss has two effects. It sets a sticky status bit that the processor can read, and it pulls the board's central active-low reset line low. The same reset line also merges three other reset sources:

- a pushbutton,
- a debug-port reset,
- an external reset sent as a differential pair, which requests reset when the positive leg is high and the negative leg is low.

When the clock comes back and no other source is active, the reset output is released. The status bit stays set. Only a firmware clear strobe or the power-up reset can clear it, and the clear strobe has no effect while the loss condition is still present.

Top module: `clkmon_reset_top`

## Requirements
- R1: The loss condition rises exactly TIMEOUT_CYCLES reference cycles after the last synchronized rising edge of the monitored clock. With the default synchronizer, `clk_lost` rises after the reference edge that comes TIMEOUT_CYCLES+3 edges after the edge that first samples the monitored clock high, and not one edge earlier.
- R2: While the loss condition is present, `sys_rst_n` is 0, one reference cycle after the condition starts.
- R3: The loss condition sets `clk_lost` to 1 on the next reference edge, and `clk_lost` stays 1 after the monitored clock returns.
- R4: A one-cycle `fw_clear` pulse clears `clk_lost` to 0 when no loss condition is present. A pulse given while the loss condition is still present leaves `clk_lost` at 1.
- R5: While `por_n` is 0, `clk_lost` is 0 and `sys_rst_n` is 0.
- R6: `btn_rst_n` = 0 at a reference edge makes `sys_rst_n` 0 after that edge.
- R7: `dbg_rst_n` = 0 at a reference edge makes `sys_rst_n` 0 after that edge.
- R8: The external pair requests reset only for `ext_rst_p`=1 with `ext_rst_n`=0. The pair values 00, 01 and 11 leave `sys_rst_n` at 1 when no other source is active.
- R9: After the monitored clock resumes, the loss condition ends within three reference cycles of its first rising edge. `sys_rst_n` then returns to 1 if no other source is active.
- R10: A monitored clock whose rising edges are never more than TIMEOUT_CYCLES-4 reference cycles apart never sets `clk_lost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running 16 MHz reference clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| mon_clk | input | 1 | Monitored processor clock output (asynchronous) |
| btn_rst_n | input | 1 | Pushbutton reset, active low |
| dbg_rst_n | input | 1 | Debug-port reset, active low |
| ext_rst_p | input | 1 | External reset pair, positive leg |
| ext_rst_n | input | 1 | External reset pair, negative leg |
| fw_clear | input | 1 | Firmware strobe that clears the loss status |
| sys_rst_n | output | 1 | Central board reset, active low, registered |
| clk_lost | output | 1 | Sticky clock-loss status, readable by firmware |

## Verification
On every cycle, the assertions check the following:
- the counter stays within its limit, and a detected edge always ends the loss condition;
- the loss condition always sets the flag and pulls the reset line;
- a clear strobe given during the loss condition never drops the flag;
- each of the three external reset sources pulls the line one cycle later.

Some behaviour can only be shown by the bench's scenarios:
- the exact edge on which the loss is declared;
- the flag staying set after the clock returns while the reset line is released;
- the clearing of the flag by power-up reset;
- the absence of false losses under a steadily toggling clock with random reset-source activity.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Width needed to hold the values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= 64'(limit)) w++;
    return w;
  endfunction

  // Reset request from the board sources (1 = reset wanted).
  function automatic logic reset_wanted(input logic lost, input logic btn_n,
                                        input logic dbg_n, input logic pos,
                                        input logic neg);
    return lost | ~btn_n | ~dbg_n | (pos & ~neg);
  endfunction

endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[LAST];

  assign rise = chain[LAST] & ~prev;

  // A rise lasts one cycle only.
  p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/clkmon_timeout.sv
module clkmon_timeout #(
  parameter int unsigned TIMEOUT_CYCLES = 158400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_seen,
  output logic lost
);
  import clkmon_pkg::*;
  localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);

  logic [CNT_W-1:0] quiet_cnt;
  logic             at_limit;

  assign at_limit = (quiet_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          quiet_cnt <= '0;
    else if (edge_seen)  quiet_cnt <= '0;
    else if (!at_limit)  quiet_cnt <= quiet_cnt + 1'b1;

  assign lost = at_limit;

  p_cnt_bounded_r1: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_cnt <= LIMIT);
  p_edge_ends_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !lost);
  p_loss_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !edge_seen) |=> lost);
endmodule

// File: rtl/clkmon_rst_combine.sv
module clkmon_rst_combine (
  input  logic clk,
  input  logic por_n,
  input  logic lost,
  input  logic btn_rst_n,
  input  logic dbg_rst_n,
  input  logic ext_rst_p,
  input  logic ext_rst_n,
  output logic sys_rst_n
);
  import clkmon_pkg::*;
  logic want;

  assign want = reset_wanted(lost, btn_rst_n, dbg_rst_n, ext_rst_p, ext_rst_n);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sys_rst_n <= 1'b0;
    else        sys_rst_n <= ~want;

  p_loss_pulls_r2: assert property (@(posedge clk) disable iff (!por_n)
    lost |=> !sys_rst_n);
  p_button_pulls_r6: assert property (@(posedge clk) disable iff (!por_n)
    !btn_rst_n |=> !sys_rst_n);
  p_debug_pulls_r7: assert property (@(posedge clk) disable iff (!por_n)
    !dbg_rst_n |=> !sys_rst_n);
  p_pair_pulls_r8: assert property (@(posedge clk) disable iff (!por_n)
    (ext_rst_p && !ext_rst_n) |=> !sys_rst_n);
endmodule

// File: rtl/clkmon_reset_top.sv
module clkmon_reset_top #(
  parameter int unsigned TIMEOUT_CYCLES = 158400,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_ref,
  input  logic por_n,
  input  logic mon_clk,
  input  logic btn_rst_n,
  input  logic dbg_rst_n,
  input  logic ext_rst_p,
  input  logic ext_rst_n,
  input  logic fw_clear,
  output logic sys_rst_n,
  output logic clk_lost
);
  logic mon_rise;
  logic loss_now;
  logic flag_q;

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_ref), .rst_n(por_n), .async_in(mon_clk), .rise(mon_rise));

  clkmon_timeout #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timeout (
    .clk(clk_ref), .rst_n(por_n), .edge_seen(mon_rise), .lost(loss_now));

  clkmon_rst_combine u_comb (
    .clk(clk_ref), .por_n(por_n), .lost(loss_now),
    .btn_rst_n(btn_rst_n), .dbg_rst_n(dbg_rst_n),
    .ext_rst_p(ext_rst_p), .ext_rst_n(ext_rst_n), .sys_rst_n(sys_rst_n));

  // Sticky status: setting wins over the firmware clear.
  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n)        flag_q <= 1'b0;
    else if (loss_now) flag_q <= 1'b1;
    else if (fw_clear) flag_q <= 1'b0;

  assign clk_lost = flag_q;

  p_loss_sets_r3: assert property (@(posedge clk_ref) disable iff (!por_n)
    loss_now |=> clk_lost);
  p_clear_blocked_r4: assert property (@(posedge clk_ref) disable iff (!por_n)
    (fw_clear && loss_now) |=> clk_lost);
  p_flag_sticky_r3: assert property (@(posedge clk_ref) disable iff (!por_n)
    (clk_lost && !fw_clear) |=> clk_lost);
  p_clear_works_r4: assert property (@(posedge clk_ref) disable iff (!por_n)
    (fw_clear && !loss_now) |=> !clk_lost);
endmodule

// File: tb/clkmon_reset_top_tb.sv
module clkmon_reset_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 40;

  logic clk_ref = 1'b0;
  logic por_n = 1'b0, mon_clk = 1'b0, btn_rst_n = 1'b1, dbg_rst_n = 1'b1;
  logic ext_rst_p = 1'b0, ext_rst_n = 1'b1, fw_clear = 1'b0;
  logic sys_rst_n, clk_lost;
  logic mon_run = 1'b0;
  int checks = 0, fails = 0;
  bit done = 0;

  clkmon_reset_top #(.TIMEOUT_CYCLES(T)) dut_i (
    .clk_ref(clk_ref), .por_n(por_n), .mon_clk(mon_clk),
    .btn_rst_n(btn_rst_n), .dbg_rst_n(dbg_rst_n), .ext_rst_p(ext_rst_p),
    .ext_rst_n(ext_rst_n), .fw_clear(fw_clear),
    .sys_rst_n(sys_rst_n), .clk_lost(clk_lost));

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  // Background monitored clock: one toggle every two reference cycles.
  initial forever begin
    repeat (2) @(negedge clk_ref);
    if (mon_run) mon_clk = ~mon_clk;
  end

  function automatic logic exp_rst_n(input logic b, input logic d,
                                     input logic p, input logic n);
    logic pair_req;
    pair_req = (p == 1'b1) && (n == 1'b0);
    return (b && d && !pair_req);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_ref); @(negedge clk_ref);
  endtask

  // Stop the monitored clock; its last rise is driven at a known negedge.
  task automatic stop_clock_and_check_boundary();
    mon_run = 1'b0;
    @(negedge clk_ref); mon_clk = 1'b0;
    repeat (3) @(negedge clk_ref);
    mon_clk = 1'b1;
    repeat (T + 3) @(posedge clk_ref);
    @(negedge clk_ref);
    chk("R1 no loss one edge early", clk_lost, 1'b0);
    chk("R1 reset still high one edge early", sys_rst_n, 1'b1);
    step();
    chk("R1/R3 loss flagged at limit", clk_lost, 1'b1);
    chk("R2 loss pulls reset", sys_rst_n, 1'b0);
  endtask

  task automatic pulse_clear();
    fw_clear = 1'b1; step(); fw_clear = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) step();
    chk("R5 flag clear in power-up reset", clk_lost, 1'b0);
    chk("R5 reset low in power-up reset", sys_rst_n, 1'b0);
    mon_run = 1'b1;
    por_n = 1'b1;
    repeat (4) step();
    chk("R10 reset released with clock running", sys_rst_n, 1'b1);

    // Directed sources
    btn_rst_n = 1'b0; step();
    chk("R6 pushbutton", sys_rst_n, 1'b0);
    btn_rst_n = 1'b1; step();
    chk("R6 pushbutton release", sys_rst_n, 1'b1);
    dbg_rst_n = 1'b0; step();
    chk("R7 debug reset", sys_rst_n, 1'b0);
    dbg_rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      ext_rst_p = c[1]; ext_rst_n = c[0]; step();
      chk("R8 external pair", sys_rst_n, (c == 2) ? 1'b0 : 1'b1);
    end
    ext_rst_p = 1'b0; ext_rst_n = 1'b1; step();

    // Random source activity with a running clock
    for (int i = 0; i < 300; i++) begin
      logic b, d, p, n;
      b = ($urandom_range(7) != 0);
      d = ($urandom_range(7) != 0);
      p = ($urandom_range(3) == 0);
      n = ($urandom_range(1) == 0);
      btn_rst_n = b; dbg_rst_n = d; ext_rst_p = p; ext_rst_n = n;
      step();
      chk("R6/R7/R8 random combine", sys_rst_n, exp_rst_n(b, d, p, n));
      if (i % 50 == 0) chk("R10 no false loss", clk_lost, 1'b0);
    end
    btn_rst_n = 1'b1; dbg_rst_n = 1'b1; ext_rst_p = 1'b0; ext_rst_n = 1'b1;
    step();
    chk("R10 no loss after random phase", clk_lost, 1'b0);

    // Clock loss, clear while missing, recovery
    stop_clock_and_check_boundary();
    repeat (5) step();
    chk("R2 reset held during loss", sys_rst_n, 1'b0);
    pulse_clear(); step();
    chk("R4 clear ignored while clock missing", clk_lost, 1'b1);
    mon_run = 1'b1;
    repeat (10) step();
    chk("R9 reset released after clock returns", sys_rst_n, 1'b1);
    chk("R3 flag stays set after return", clk_lost, 1'b1);
    pulse_clear();
    chk("R4 clear after return", clk_lost, 1'b0);
    repeat (3) step();
    chk("R4 flag stays clear", clk_lost, 1'b0);

    // Loss then power-up reset
    stop_clock_and_check_boundary();
    por_n = 1'b0; #1;
    chk("R5 power-up reset clears flag", clk_lost, 1'b0);
    chk("R5 power-up reset holds line", sys_rst_n, 1'b0);
    mon_run = 1'b1;
    step(); por_n = 1'b1;
    repeat (6) step();
    chk("R9 line released after power-up", sys_rst_n, 1'b1);
    chk("R5 flag still clear", clk_lost, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_ref);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule